// File: doc/BRIEF.md
# In-Order Retirement Buffer with Deferred Traps

This block keeps the instructions of an out-of-order core in their program order while they are in flight. The rename stage pushes one entry per cycle. Each entry holds the destination architectural register, the physical tag newly given to that register, and the tag it replaced. The push returns a slot number, which travels with the instruction through execution. Execution units report back through a completion port addressed by that slot number. They may report in any order and may mark the instruction as faulted, along with a cause code and, optionally, the result value.

Retirement happens only at the oldest slot. When the oldest entry has completed without fault, the block presents it on the commit port. The replaced physical tag shown there can go back to the free list, and the result comes from the buffer rather than from the register file.

A faulted entry does not disturb the machine when it completes. Only when it becomes the oldest does the block raise the trap output for one cycle, with the slot number and cause. In that same cycle it drops that entry and every younger one. The rename map and the free list use this pulse to roll back.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and neither `commit_valid` nor `exc_valid` is asserted.
- R2: Each accepted push takes slot `alloc_idx`, and the next slot offered is (`alloc_idx`+1) mod DEPTH. Once DEPTH entries are held, `alloc_ready` is 0 and a push request is not taken.
- R3: Completions may arrive in any slot order. Nothing is committed until the oldest entry has completed. Entries then commit one per cycle, oldest first, and each shows the register, new tag and previous tag given at its push.
- R4: `commit_data` carries the value supplied with that entry's completion.
- R5: A faulted completion raises nothing while older entries are still pending. Older entries that complete normally still commit ahead of the faulted one.
- R6: When the oldest entry is faulted, `exc_valid` is 1 for one cycle with `exc_idx` equal to its slot and `exc_cause` equal to its cause, and `commit_valid` is 0. From the next cycle on, that entry and all younger ones are gone and never commit.
- R7: During the trap cycle `alloc_ready` is 0 and a push request is not taken.
- R8: After a trap, the buffer is empty and the next push takes the faulted entry's slot, so `alloc_idx` equals the previous `exc_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Push request from rename |
| alloc_areg | input | AREG_W | Destination architectural register |
| alloc_new_tag | input | PTAG_W | Physical tag newly given to the register |
| alloc_old_tag | input | PTAG_W | Physical tag the register mapped to before |
| alloc_ready | output | 1 | Push will be taken this cycle |
| alloc_idx | output | IDX_W | Slot the next push receives |
| cpl_valid | input | 1 | Completion report |
| cpl_idx | input | IDX_W | Slot being completed |
| cpl_fault | input | 1 | Completion carries a fault |
| cpl_cause | input | CAUSE_W | Fault cause code |
| cpl_data | input | DATA_W | Result value |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_areg | output | AREG_W | Retiring register |
| commit_new_tag | output | PTAG_W | Retiring physical tag |
| commit_old_tag | output | PTAG_W | Tag to hand back to the free list |
| commit_data | output | DATA_W | Retiring result value |
| exc_valid | output | 1 | Trap and flush pulse |
| exc_idx | output | IDX_W | Slot of the faulted entry |
| exc_cause | output | CAUSE_W | Cause of the faulted entry |

## Verification
A bad head or tail pointer shows in the very next push as a wrong `alloc_idx`. It also shows as a wrong register or tag on the first commit afterwards. A lost or stray completion bit shows within a cycle of the oldest entry's completion, either as a commit stream that stalls or as one that runs ahead of an older, unfinished entry. A flush that leaves entries behind shows one cycle after the trap, through `alloc_idx` and through commits of entries that should have been discarded. A sweep places the fault at every position of a full buffer, starting from several head positions, so that each of these effects is exposed at the ports.

// File: rtl/retire_buf_pkg.sv
// Shared types for the in-order retirement buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package retire_buf_pkg;
    // Classification of the oldest slot, decoded once per cycle.
    typedef enum logic [1:0] {
        HEAD_EMPTY  = 2'd0,
        HEAD_WAIT   = 2'd1,
        HEAD_RETIRE = 2'd2,
        HEAD_TRAP   = 2'd3
    } head_state_e;
endpackage

// File: rtl/retire_buf_ptrs.sv
// Head and tail pointers of the circular buffer, each with one wrap bit.
// Assumes DEPTH is a power of two. On flush the tail falls back to the head.
module retire_buf_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head_q, tail_q;

    // Advance the pointers on push and pop, or collapse the tail onto the head on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            tail_q <= head_q;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    // The slot fields agree and the wrap bits differ only when the buffer is full.
    always_comb begin
        head_idx = head_q[IDX_W-1:0];
        tail_idx = tail_q[IDX_W-1:0];
        full     = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);
    end
endmodule

// File: rtl/retire_buf_entries.sv
// Entry storage: per-slot status bits plus payload arrays.
// Assumes push never targets an occupied slot and that pop always targets the head.
// Completions to unoccupied slots are dropped. A flush clears every occupied bit.
module retire_buf_entries #(
    parameter int DEPTH       = 8,
    parameter int AREG_W      = 5,
    parameter int PTAG_W      = 7,
    parameter int DATA_W      = 64,
    parameter int CAUSE_W     = 4,
    parameter bit KEEP_RESULT = 1'b1,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [AREG_W-1:0]  wr_areg,
    input  logic [PTAG_W-1:0]  wr_new_tag,
    input  logic [PTAG_W-1:0]  wr_old_tag,
    input  logic               cpl_valid,
    input  logic [IDX_W-1:0]   cpl_idx,
    input  logic               cpl_fault,
    input  logic [CAUSE_W-1:0] cpl_cause,
    input  logic [DATA_W-1:0]  cpl_data,
    input  logic               pop,
    input  logic               flush,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_live,
    output logic               rd_done,
    output logic               rd_fault,
    output logic [AREG_W-1:0]  rd_areg,
    output logic [PTAG_W-1:0]  rd_new_tag,
    output logic [PTAG_W-1:0]  rd_old_tag,
    output logic [CAUSE_W-1:0] rd_cause,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DEPTH-1:0] live_q, done_q, fault_q;
    logic [AREG_W-1:0]  areg_q  [DEPTH];
    logic [PTAG_W-1:0]  newt_q  [DEPTH];
    logic [PTAG_W-1:0]  oldt_q  [DEPTH];
    logic [CAUSE_W-1:0] cause_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Status bits of one slot: set on push, marked on completion, cleared on retire or flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[g]  <= 1'b0;
                done_q[g]  <= 1'b0;
                fault_q[g] <= 1'b0;
            end else if (flush) begin
                live_q[g]  <= 1'b0;
            end else if (push && wr_idx == IDX_W'(g)) begin
                live_q[g]  <= 1'b1;
                done_q[g]  <= 1'b0;
                fault_q[g] <= 1'b0;
            end else if (pop && rd_idx == IDX_W'(g)) begin
                live_q[g]  <= 1'b0;
            end else if (cpl_valid && cpl_idx == IDX_W'(g) && live_q[g]) begin
                done_q[g]  <= 1'b1;
                fault_q[g] <= cpl_fault;
            end
        end
    end

    // Payload written at push time: register and both tags.
    always_ff @(posedge clk) begin
        if (push) begin
            areg_q[wr_idx] <= wr_areg;
            newt_q[wr_idx] <= wr_new_tag;
            oldt_q[wr_idx] <= wr_old_tag;
        end
    end

    // Cause code recorded with each accepted completion.
    always_ff @(posedge clk) begin
        if (cpl_valid && live_q[cpl_idx]) cause_q[cpl_idx] <= cpl_cause;
    end

    if (KEEP_RESULT) begin : g_result
        logic [DATA_W-1:0] data_q [DEPTH];
        // Result value held in the entry so retirement skips the register file.
        always_ff @(posedge clk) begin
            if (cpl_valid && live_q[cpl_idx]) data_q[cpl_idx] <= cpl_data;
        end
        assign rd_data = data_q[rd_idx];
    end else begin : g_no_result
        assign rd_data = '0;
    end

    // Read port for the head slot.
    always_comb begin
        rd_live    = live_q[rd_idx];
        rd_done    = done_q[rd_idx];
        rd_fault   = fault_q[rd_idx];
        rd_areg    = areg_q[rd_idx];
        rd_new_tag = newt_q[rd_idx];
        rd_old_tag = oldt_q[rd_idx];
        rd_cause   = cause_q[rd_idx];
    end
endmodule

// File: rtl/retire_buf_head.sv
// Decides what the oldest slot does this cycle: nothing, wait, retire or trap.
// Assumes its inputs describe the slot at the head pointer.
module retire_buf_head
    import retire_buf_pkg::*;
(
    input  logic        live,
    input  logic        done,
    input  logic        fault,
    output head_state_e state,
    output logic        retire,
    output logic        trap
);
    // Classify the head and derive the retire and trap strobes.
    always_comb begin
        if (!live)      state = HEAD_EMPTY;
        else if (!done) state = HEAD_WAIT;
        else if (fault) state = HEAD_TRAP;
        else            state = HEAD_RETIRE;
        retire = (state == HEAD_RETIRE);
        trap   = (state == HEAD_TRAP);
    end
endmodule

// File: rtl/inorder_retire_buf.sv
// In-order retirement buffer: pushes in program order, accepts completions in any
// order, retires from the head, and traps when a faulted entry is the oldest.
// Assumes DEPTH is a power of two and that the consumer takes every commit offered.
module inorder_retire_buf #(
    parameter int DEPTH       = 8,
    parameter int AREG_W      = 5,
    parameter int PTAG_W      = 7,
    parameter int DATA_W      = 64,
    parameter int CAUSE_W     = 4,
    parameter bit KEEP_RESULT = 1'b1,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [AREG_W-1:0]  alloc_areg,
    input  logic [PTAG_W-1:0]  alloc_new_tag,
    input  logic [PTAG_W-1:0]  alloc_old_tag,
    output logic               alloc_ready,
    output logic [IDX_W-1:0]   alloc_idx,
    input  logic               cpl_valid,
    input  logic [IDX_W-1:0]   cpl_idx,
    input  logic               cpl_fault,
    input  logic [CAUSE_W-1:0] cpl_cause,
    input  logic [DATA_W-1:0]  cpl_data,
    output logic               commit_valid,
    output logic [AREG_W-1:0]  commit_areg,
    output logic [PTAG_W-1:0]  commit_new_tag,
    output logic [PTAG_W-1:0]  commit_old_tag,
    output logic [DATA_W-1:0]  commit_data,
    output logic               exc_valid,
    output logic [IDX_W-1:0]   exc_idx,
    output logic [CAUSE_W-1:0] exc_cause
);
    import retire_buf_pkg::*;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic full, push, retire, trap;
    logic h_live, h_done, h_fault;
    head_state_e h_state;

    // Push only when there is room and no trap is flushing the buffer.
    always_comb begin
        alloc_ready = !full && !trap;
        push        = alloc_valid && alloc_ready;
        alloc_idx   = tail_idx;
    end

    retire_buf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (retire),
        .flush    (trap),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full)
    );

    retire_buf_entries #(
        .DEPTH(DEPTH), .AREG_W(AREG_W), .PTAG_W(PTAG_W),
        .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .KEEP_RESULT(KEEP_RESULT)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .wr_idx     (tail_idx),
        .wr_areg    (alloc_areg),
        .wr_new_tag (alloc_new_tag),
        .wr_old_tag (alloc_old_tag),
        .cpl_valid  (cpl_valid),
        .cpl_idx    (cpl_idx),
        .cpl_fault  (cpl_fault),
        .cpl_cause  (cpl_cause),
        .cpl_data   (cpl_data),
        .pop        (retire),
        .flush      (trap),
        .rd_idx     (head_idx),
        .rd_live    (h_live),
        .rd_done    (h_done),
        .rd_fault   (h_fault),
        .rd_areg    (commit_areg),
        .rd_new_tag (commit_new_tag),
        .rd_old_tag (commit_old_tag),
        .rd_cause   (exc_cause),
        .rd_data    (commit_data)
    );

    retire_buf_head u_head (
        .live   (h_live),
        .done   (h_done),
        .fault  (h_fault),
        .state  (h_state),
        .retire (retire),
        .trap   (trap)
    );

    // Drive the retire and trap outputs from the head decision.
    always_comb begin
        commit_valid = retire;
        exc_valid    = trap;
        exc_idx      = head_idx;
    end
endmodule

// File: rtl/retire_buf_sva.sv
// Port-level checker for the retirement buffer, with its own occupancy model.
// Assumes it is attached to inorder_retire_buf through the bind below.
module retire_buf_sva #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             commit_valid,
    input logic             exc_valid,
    input logic [IDX_W-1:0] exc_idx
);
    localparam logic [IDX_W:0] FULL_OCC = (IDX_W + 1)'(DEPTH);

    logic [IDX_W:0] occ;

    // Independent count of held entries, built from port events only.
    always_ff @(posedge clk) begin
        if (!rst_n || exc_valid) occ <= '0;
        else occ <= occ + (IDX_W + 1)'(alloc_valid && alloc_ready) - (IDX_W + 1)'(commit_valid);
    end

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1));

    p_ready_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (alloc_ready == (occ != FULL_OCC)));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);

    p_no_commit_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && exc_valid));

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (!commit_valid && !exc_valid && alloc_ready));

    p_trap_blocks_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !alloc_ready);

    p_restart_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> alloc_idx == $past(exc_idx));
endmodule

bind inorder_retire_buf retire_buf_sva #(.DEPTH(DEPTH)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_idx    (alloc_idx),
    .commit_valid (commit_valid),
    .exc_valid    (exc_valid),
    .exc_idx      (exc_idx)
);

// File: tb/sim_inorder_retire_buf.sv
module sim_inorder_retire_buf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AREG_W = 5;
    localparam int PTAG_W = 6;
    localparam int DATA_W = 16;
    localparam int CAUSE_W = 4;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [AREG_W-1:0] alloc_areg = '0;
    logic [PTAG_W-1:0] alloc_new_tag = '0, alloc_old_tag = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_idx;
    logic cpl_valid = 1'b0, cpl_fault = 1'b0;
    logic [IDX_W-1:0] cpl_idx = '0;
    logic [CAUSE_W-1:0] cpl_cause = '0;
    logic [DATA_W-1:0] cpl_data = '0;
    logic commit_valid, exc_valid;
    logic [AREG_W-1:0] commit_areg;
    logic [PTAG_W-1:0] commit_new_tag, commit_old_tag;
    logic [DATA_W-1:0] commit_data;
    logic [IDX_W-1:0] exc_idx;
    logic [CAUSE_W-1:0] exc_cause;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inorder_retire_buf #(
        .DEPTH(DEPTH), .AREG_W(AREG_W), .PTAG_W(PTAG_W),
        .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .KEEP_RESULT(1'b1)
    ) u0 (.*);

    task automatic chk(input string req, input int act, input int exp_v);
        nchk++;
        if (act != exp_v) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int areg, input int nt, input int ot);
        alloc_valid = 1'b1; alloc_areg = AREG_W'(areg);
        alloc_new_tag = PTAG_W'(nt); alloc_old_tag = PTAG_W'(ot);
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic complete(input int idx, input bit f, input int cause, input int data);
        cpl_valid = 1'b1; cpl_idx = IDX_W'(idx); cpl_fault = f;
        cpl_cause = CAUSE_W'(cause); cpl_data = DATA_W'(data);
        tick();
        cpl_valid = 1'b0; cpl_fault = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        chk("R1 commit_valid", int'(commit_valid), 0);
        chk("R1 exc_valid", int'(exc_valid), 0);

        // R2: fill the buffer, slots in sequence, then stall
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 slot", int'(alloc_idx), i);
            push(i + 1, 10 + i, 20 + i);
        end
        chk("R2 full not ready", int'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_areg = 5'd31;
        tick();
        alloc_valid = 1'b0;
        chk("R2 still full", int'(alloc_ready), 0);

        // R3: complete youngest first; no commit until the oldest is done
        for (int i = DEPTH - 1; i > 0; i--) begin
            complete(i, 1'b0, 0, 100 + i);
            chk("R3 no early commit", int'(commit_valid), 0);
        end
        complete(0, 1'b0, 0, 100);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R3 commit_valid", int'(commit_valid), 1);
            chk("R3 areg", int'(commit_areg), k + 1);
            chk("R3 new tag", int'(commit_new_tag), 10 + k);
            chk("R3 old tag", int'(commit_old_tag), 20 + k);
            chk("R4 data", int'(commit_data), 100 + k);
            tick();
        end
        chk("R3 drained", int'(commit_valid), 0);
        chk("R2 wrap slot", int'(alloc_idx), 0);

        // R5..R8: fault in the middle, older entry still pending
        push(7, 30, 40);
        push(8, 31, 41);
        push(9, 32, 42);
        complete(1, 1'b1, 5, 0);
        chk("R5 no trap while older pending", int'(exc_valid), 0);
        chk("R5 no commit", int'(commit_valid), 0);
        complete(2, 1'b0, 0, 222);
        chk("R5 still no trap", int'(exc_valid), 0);
        complete(0, 1'b0, 0, 111);
        chk("R5 older commits", int'(commit_valid), 1);
        chk("R5 older areg", int'(commit_areg), 7);
        chk("R5 no trap with commit", int'(exc_valid), 0);
        tick();
        chk("R6 trap", int'(exc_valid), 1);
        chk("R6 trap idx", int'(exc_idx), 1);
        chk("R6 trap cause", int'(exc_cause), 5);
        chk("R6 no commit in trap", int'(commit_valid), 0);
        chk("R7 not ready in trap", int'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_areg = 5'd11;
        tick();
        alloc_valid = 1'b0;
        chk("R6 trap one cycle", int'(exc_valid), 0);
        chk("R7 push ignored", int'(alloc_idx), 1);
        chk("R8 ready after flush", int'(alloc_ready), 1);
        for (int w = 0; w < 3; w++) begin
            chk("R6 younger discarded", int'(commit_valid), 0);
            tick();
        end
        push(12, 50, 51);
        complete(1, 1'b0, 0, 77);
        chk("R8 restart commit", int'(commit_valid), 1);
        chk("R8 restart areg", int'(commit_areg), 12);
        chk("R4 restart data", int'(commit_data), 77);
        tick();

        // Sweep: full buffer, fault at each position, head moving each round
        base = 2;
        for (int j = 0; j < DEPTH; j++) begin
            for (int i = 0; i < DEPTH; i++) begin
                chk("R2 sweep slot", int'(alloc_idx), (base + i) % DEPTH);
                push((j * 4 + i) % 32, (j * 4 + i) % 64, (j * 4 + i + 16) % 64);
            end
            for (int i = DEPTH - 1; i >= 0; i--)
                complete((base + i) % DEPTH, (i == j), j + 1, 1000 + j * 4 + i);
            for (int k = 0; k < j; k++) begin
                chk("R5 sweep commit", int'(commit_valid), 1);
                chk("R3 sweep areg", int'(commit_areg), (j * 4 + k) % 32);
                chk("R3 sweep old tag", int'(commit_old_tag), (j * 4 + k + 16) % 64);
                chk("R4 sweep data", int'(commit_data), 1000 + j * 4 + k);
                tick();
            end
            chk("R6 sweep trap", int'(exc_valid), 1);
            chk("R6 sweep idx", int'(exc_idx), (base + j) % DEPTH);
            chk("R6 sweep cause", int'(exc_cause), j + 1);
            chk("R6 sweep no commit", int'(commit_valid), 0);
            tick();
            base = (base + j) % DEPTH;
            chk("R8 sweep restart", int'(alloc_idx), base);
            chk("R6 sweep empty", int'(commit_valid), 0);
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule